// File: doc/BRIEF.md
# SPI Serial Memory Slave Front End

This block is the serial-side controller of a 2048-byte byte-addressed nonvolatile memory. It watches a four-wire SPI bus (serial clock, serial data in, serial data out and an active-low select), collects an instruction byte and a two-byte address, and turns each transfer into single-cycle strobes on an internal array port and an internal status-register port. The storage array, the write-enable latch and the self-timed programming engine all sit outside. The block only issues the requests and returns read data serially.

All bus pins are brought into the system clock domain through a synchronizer and their edges are detected there. Serial data is sampled on each rising SCK edge and shifted out on each falling edge, so a host may idle the clock low (mode 0) or high (mode 3). A hold input freezes the transfer mid-frame and releases the output pin, and the transfer then picks up at the same bit. Each SCK phase, high and low, must last at least `SYNC_STAGES + 4` system clocks. The array port must present `mem_rdata` by the second system-clock edge after `mem_rd` is seen high.

Top module: `spi_mem_slave`

## Requirements
- R1: Data on `si` is taken on rising SCK edges and `so` changes only after falling SCK edges, MSB first. A frame may begin with SCK idle low (mode 0) or idle high (mode 3), and both give the same results.
- R2: Opcode 0x03 (read) is followed by two address bytes, high byte first. Only the low 11 bits are used and the upper 5 are ignored. The block then issues one single-cycle `mem_rd` at that address and shifts the returned byte out on `so`.
- R3: A read keeps streaming. After each output byte the address is incremented and the next byte fetched, and the address wraps from 0x7FF to 0x000.
- R4: Opcode 0x02 (write) is followed by two address bytes (upper 5 bits ignored). Each complete data byte then raises one single-cycle `mem_wr` with that address and `mem_wdata`, and the address increments with the same wrap at 0x7FF.
- R5: Completing opcode 0x06 gives exactly one `wel_set` pulse. Completing opcode 0x04 gives exactly one `wel_clr` pulse.
- R6: Opcode 0x05 shifts out the `sr_rdata` value again for every further byte of the frame.
- R7: Opcode 0x01 takes the first data byte as one `sr_wr` pulse carrying that byte on `sr_wdata`. Later bytes in the same frame have no effect.
- R8: While `hold_n` is low, SCK and SI transitions are ignored, no strobe is produced, and the bit and byte position is kept. After release the frame continues as if the hold had not occurred.
- R9: `so_oe` is low whenever `cs_n` is high or `hold_n` is low, allowing for the synchronizer delay. It is high only during the data phase of a read or status read.
- R10: Raising `cs_n` at any bit aborts the instruction with no strobe. The next frame starts again with an opcode.
- R11: An opcode other than the six above produces no strobe and keeps `so_oe` low until `cs_n` rises.
- R12: After reset all strobes and `so_oe` are low, and at most one of `mem_rd`, `mem_wr`, `sr_wr`, `wel_set`, `wel_clr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low transfer pause |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for the `so` pad driver |
| mem_rd | output | 1 | Array read strobe |
| mem_wr | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array byte address |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data |
| sr_rdata | input | 8 | Current status register value |
| sr_wr | output | 1 | Status register write strobe |
| sr_wdata | output | 8 | Status register write data |
| wel_set | output | 1 | Write-enable latch set request |
| wel_clr | output | 1 | Write-enable latch clear request |

## Verification
The bench builds the block with its defaults: an 11-bit address inside a 16-bit address field and a two-stage synchronizer. The 11-bit width puts the 0x7FF-to-0x000 wrap within a four-byte read or a three-byte write. The five unused address bits are set so that dropping them can be seen. With two synchronizer stages, an SCK half period of eight system clocks leaves room for the fetch latency, so the bench can check a hold placed inside an address byte and inside a data byte against the exact bit stream.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
   localparam int BYTE_W = 8;

   localparam logic [7:0] OPC_STAT_WR = 8'h01;
   localparam logic [7:0] OPC_ARR_WR  = 8'h02;
   localparam logic [7:0] OPC_ARR_RD  = 8'h03;
   localparam logic [7:0] OPC_LATCH_CLR = 8'h04;
   localparam logic [7:0] OPC_STAT_RD = 8'h05;
   localparam logic [7:0] OPC_LATCH_SET = 8'h06;

   typedef enum logic [2:0] {
      K_NONE, K_ARR_RD, K_ARR_WR, K_STAT_RD, K_STAT_WR
   } kind_e;

   typedef enum logic [1:0] {
      PH_OPC, PH_ADDR, PH_DATA, PH_SKIP
   } phase_e;

   function automatic kind_e kind_of(input logic [7:0] opc);
      case (opc)
         OPC_ARR_RD:  return K_ARR_RD;
         OPC_ARR_WR:  return K_ARR_WR;
         OPC_STAT_RD: return K_STAT_RD;
         OPC_STAT_WR: return K_STAT_WR;
         default:     return K_NONE;
      endcase
   endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int WIDTH   = 4,
   parameter int STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
   import spi_mem_pkg::*;
#(
   parameter int ADDR_W     = 11,
   parameter int ADDR_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              rise,
   input  logic              si_s,
   output logic              out_phase,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic              sr_wr,
   output logic [BYTE_W-1:0] sr_wdata,
   output logic              sr_load,
   output logic              wel_set,
   output logic              wel_clr
);
   localparam int CNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
   localparam logic [CNT_W-1:0] LAST_ABYTE = CNT_W'(ADDR_BYTES - 1);

   logic [2:0]        bit_q;
   logic [6:0]        rx_q;
   logic [BYTE_W-1:0] rx_byte;
   logic [CNT_W-1:0]  abyte_q;
   logic [ADDR_W-1:0] addr_q, addr_nx, addr_inc;
   phase_e            ph_q;
   kind_e             kind_q;

   assign rx_byte  = {rx_q, si_s};
   assign addr_nx  = ADDR_W'({addr_q, rx_byte});
   assign addr_inc = addr_q + ADDR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= '0; rx_q <= '0; abyte_q <= '0; addr_q <= '0;
         ph_q <= PH_OPC; kind_q <= K_NONE;
         mem_rd <= 1'b0; mem_wr <= 1'b0; sr_wr <= 1'b0; sr_load <= 1'b0;
         wel_set <= 1'b0; wel_clr <= 1'b0;
         mem_addr <= '0; mem_wdata <= '0; sr_wdata <= '0;
      end else begin
         mem_rd <= 1'b0; mem_wr <= 1'b0; sr_wr <= 1'b0; sr_load <= 1'b0;
         wel_set <= 1'b0; wel_clr <= 1'b0;
         if (!sel) begin
            bit_q <= '0; abyte_q <= '0; ph_q <= PH_OPC; kind_q <= K_NONE;
         end else if (rise) begin
            rx_q  <= rx_byte[6:0];
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
               unique case (ph_q)
                  PH_OPC: begin
                     kind_q <= kind_of(rx_byte);
                     case (rx_byte)
                        OPC_ARR_RD, OPC_ARR_WR: ph_q <= PH_ADDR;
                        OPC_STAT_RD: begin ph_q <= PH_DATA; sr_load <= 1'b1; end
                        OPC_STAT_WR: ph_q <= PH_DATA;
                        OPC_LATCH_SET: begin ph_q <= PH_SKIP; wel_set <= 1'b1; end
                        OPC_LATCH_CLR: begin ph_q <= PH_SKIP; wel_clr <= 1'b1; end
                        default: ph_q <= PH_SKIP;
                     endcase
                  end
                  PH_ADDR: begin
                     addr_q  <= addr_nx;
                     abyte_q <= abyte_q + CNT_W'(1);
                     if (abyte_q == LAST_ABYTE) begin
                        ph_q <= PH_DATA;
                        if (kind_q == K_ARR_RD) begin
                           mem_rd   <= 1'b1;
                           mem_addr <= addr_nx;
                        end
                     end
                  end
                  PH_DATA: begin
                     case (kind_q)
                        K_ARR_RD: begin
                           mem_rd <= 1'b1; mem_addr <= addr_inc; addr_q <= addr_inc;
                        end
                        K_ARR_WR: begin
                           mem_wr <= 1'b1; mem_addr <= addr_q; mem_wdata <= rx_byte;
                           addr_q <= addr_inc;
                        end
                        K_STAT_RD: sr_load <= 1'b1;
                        K_STAT_WR: begin
                           sr_wr <= 1'b1; sr_wdata <= rx_byte; ph_q <= PH_SKIP;
                        end
                        default: ph_q <= PH_SKIP;
                     endcase
                  end
                  PH_SKIP: ;
               endcase
            end
         end
      end
   end

   assign out_phase = sel && (ph_q == PH_DATA) &&
                      ((kind_q == K_ARR_RD) || (kind_q == K_STAT_RD));
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
   import spi_mem_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              fall,
   input  logic              out_phase,
   input  logic              mem_rd,
   input  logic [BYTE_W-1:0] mem_rdata,
   input  logic              sr_load,
   input  logic [BYTE_W-1:0] sr_rdata,
   output logic              so
);
   logic              rd_d;
   logic [BYTE_W-1:0] tx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_d <= 1'b0; tx_q <= '0; so <= 1'b0;
      end else begin
         rd_d <= mem_rd;
         if (rd_d)         tx_q <= mem_rdata;
         else if (sr_load) tx_q <= sr_rdata;
         else if (fall && out_phase) tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
         if (!sel)                   so <= 1'b0;
         else if (fall && out_phase) so <= tx_q[BYTE_W-1];
      end
   end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
   import spi_mem_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int ADDR_FRAME_W = 16,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              cs_n,
   input  logic              si,
   input  logic              hold_n,
   output logic              so,
   output logic              so_oe,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   input  logic [7:0]        sr_rdata,
   output logic              sr_wr,
   output logic [7:0]        sr_wdata,
   output logic              wel_set,
   output logic              wel_clr
);
   localparam int ADDR_BYTES = ADDR_FRAME_W / BYTE_W;

   if (ADDR_W < 1 || ADDR_W > ADDR_FRAME_W) begin : g_bad_aw
      $error("ADDR_W must lie in 1..ADDR_FRAME_W");
   end
   if (ADDR_FRAME_W % BYTE_W != 0 || ADDR_FRAME_W < BYTE_W) begin : g_bad_fw
      $error("ADDR_FRAME_W must be a whole number of bytes");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [3:0] pins_s;
   logic       sck_s, si_s, cs_s, hold_s, sck_p;
   logic       sel, go, rise, fall, out_phase, sr_load;

   spi_in_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sck, si, cs_n, hold_n}), .q(pins_s)
   );
   assign {sck_s, si_s, cs_s, hold_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_p <= 1'b0;
      else        sck_p <= sck_s;
   end

   assign sel  = ~cs_s;
   assign go   = sel & hold_s;
   assign rise = go & sck_s & ~sck_p;
   assign fall = go & ~sck_s & sck_p;

   spi_cmd_ctrl #(.ADDR_W(ADDR_W), .ADDR_BYTES(ADDR_BYTES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .sel(sel), .rise(rise), .si_s(si_s),
      .out_phase(out_phase), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sr_wr(sr_wr),
      .sr_wdata(sr_wdata), .sr_load(sr_load), .wel_set(wel_set), .wel_clr(wel_clr)
   );

   spi_tx_shift u_tx (
      .clk(clk), .rst_n(rst_n), .sel(sel), .fall(fall), .out_phase(out_phase),
      .mem_rd(mem_rd), .mem_rdata(mem_rdata), .sr_load(sr_load),
      .sr_rdata(sr_rdata), .so(so)
   );

   assign so_oe = out_phase & hold_s;
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic hold_n,
   input logic so_oe,
   input logic mem_rd,
   input logic mem_wr,
   input logic sr_wr,
   input logic wel_set,
   input logic wel_clr
);
   logic [SYNC_STAGES-1:0] cs_h, hd_h;
   logic cs_late, hold_late, any_strb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_h <= '1; hd_h <= '1;
      end else begin
         cs_h <= {cs_h[SYNC_STAGES-2:0], cs_n};
         hd_h <= {hd_h[SYNC_STAGES-2:0], hold_n};
      end
   end

   assign cs_late   = cs_h[SYNC_STAGES-1];
   assign hold_late = hd_h[SYNC_STAGES-1];
   assign any_strb  = mem_rd | mem_wr | sr_wr | wel_set | wel_clr;

   AST_OE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) cs_late |-> !so_oe); // R9
   AST_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !hold_late |-> !so_oe); // R8
   AST_QUIET_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) $past(cs_late) |-> !any_strb); // R10
   AST_QUIET_HELD: assert property (@(posedge clk) disable iff (!rst_n) $past(!hold_late) |-> !any_strb); // R8
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({mem_rd, mem_wr, sr_wr, wel_set, wel_clr})); // R12
   AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> !mem_rd); // R2
   AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |=> !mem_wr); // R4
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so_oe(so_oe),
   .mem_rd(mem_rd), .mem_wr(mem_wr), .sr_wr(sr_wr),
   .wel_set(wel_set), .wel_clr(wel_clr)
);

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 11;
   localparam int HALF = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
   logic so, so_oe, mem_rd, mem_wr, sr_wr, wel_set, wel_clr;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata = 8'h00, sr_rdata = 8'h00, sr_wdata;

   spi_mem_slave dut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
      .so(so), .so_oe(so_oe), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sr_rdata(sr_rdata),
      .sr_wr(sr_wr), .sr_wdata(sr_wdata), .wel_set(wel_set), .wel_clr(wel_clr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int total = 0, bad = 0;
   int n_set = 0, n_clr = 0;
   logic [7:0] mem [2048];
   logic [AW+7:0] wq[$];
   logic [7:0] srq[$];
   logic [2:0] cs_hist = 3'b111, hd_hist = 3'b111;
   bit mode3 = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Array model and strobe recorder, a quarter period after the active edge
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      cs_hist = {cs_hist[1:0], cs_n};
      hd_hist = {hd_hist[1:0], hold_n};
      if (rst_n) begin
         if (mem_rd) mem_rdata = mem[mem_addr];
         if (mem_wr) wq.push_back({mem_addr, mem_wdata});
         if (sr_wr) srq.push_back(sr_wdata);
         if (wel_set) n_set++;
         if (wel_clr) n_clr++;
         if (cs_hist == 3'b111) chk(!so_oe, "R9", "so_oe while deselected", so_oe, 0);
         if (hd_hist == 3'b000) chk(!so_oe, "R8", "so_oe while held", so_oe, 0);
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame_start(input bit m3);
      mode3 = m3;
      @(negedge clk) sck = m3;
      wait_clk(HALF);
      cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic frame_end();
      wait_clk(HALF);
      if (!mode3) sck = 1'b0;
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(2*HALF);
   endtask

   task automatic hold_gap();
      @(negedge clk) hold_n = 1'b0;
      wait_clk(HALF);
      chk(!so_oe, "R9", "so_oe during hold", so_oe, 0);
      for (int k = 0; k < 2; k++) begin
         sck = ~sck; si = ~si;
         wait_clk(HALF);
      end
      hold_n = 1'b1;
      wait_clk(HALF);
   endtask

   // nbits bits of tx, MSB first; a hold is inserted before bit index hold_at (-1: none)
   task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_at,
                       output logic [7:0] rx);
      rx = 8'h00;
      for (int i = 7; i > 7 - nbits; i--) begin
         if (i == hold_at) hold_gap();
         @(negedge clk) sck = 1'b0; si = tx[i];
         wait_clk(HALF);
         rx[i] = so;
         sck = 1'b1;
         wait_clk(HALF - 1);
      end
   endtask

   task automatic byte8(input logic [7:0] tx, output logic [7:0] rx);
      xfer(tx, 8, -1, rx);
   endtask

   function automatic logic [7:0] mem_at(input int a);
      return mem[a & 11'h7FF];
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] r;
      int ws, ss, ns, nc;
      for (int i = 0; i < 2048; i++) mem[i] = 8'(i * 7 + 3);

      wait_clk(5);
      chk(!so_oe, "R12", "so_oe in reset", so_oe, 0);
      chk(!(mem_rd | mem_wr | sr_wr | wel_set | wel_clr), "R12", "strobes in reset", 1, 0);
      rst_n = 1'b1;
      wait_clk(5);
      chk(!so_oe, "R12", "so_oe after reset", so_oe, 0);

      // R5 latch set in mode 0, latch clear in mode 3 (R1)
      frame_start(1'b0); byte8(8'h06, r); frame_end();
      chk(n_set == 1, "R5", "wel_set pulses", n_set, 1);
      frame_start(1'b1); byte8(8'h04, r); frame_end();
      chk(n_clr == 1, "R1", "wel_clr pulses in mode 3", n_clr, 1);

      // R4 write with ignored upper address bits and wrap
      frame_start(1'b0);
      byte8(8'h02, r); byte8(8'hF7, r); byte8(8'hFE, r);
      byte8(8'hA1, r); byte8(8'hB2, r); byte8(8'hC3, r);
      frame_end();
      chk(wq.size() == 3, "R4", "write count", wq.size(), 3);
      if (wq.size() == 3) begin
         chk(wq[0] == {11'h7FE, 8'hA1}, "R4", "write 0", wq[0], {11'h7FE, 8'hA1});
         chk(wq[1] == {11'h7FF, 8'hB2}, "R4", "write 1", wq[1], {11'h7FF, 8'hB2});
         chk(wq[2] == {11'h000, 8'hC3}, "R4", "write 2 wrapped", wq[2], {11'h000, 8'hC3});
      end
      wq.delete();

      // R2 read in mode 0
      frame_start(1'b0);
      byte8(8'h03, r); byte8(8'h00, r); byte8(8'h10, r);
      for (int b = 0; b < 3; b++) begin
         byte8(8'h00, r);
         chk(r == mem_at(16 + b), "R2", "read byte", r, mem_at(16 + b));
      end
      chk(so_oe, "R9", "so_oe in read data", so_oe, 1);
      frame_end();
      chk(!so_oe, "R9", "so_oe after deselect", so_oe, 0);

      // R3 wrap in mode 3, upper bits set (R1)
      frame_start(1'b1);
      byte8(8'h03, r); byte8(8'hFF, r); byte8(8'hFE, r);
      for (int b = 0; b < 4; b++) begin
         byte8(8'h5A, r);
         chk(r == mem_at(2046 + b), "R3", "wrapping read", r, mem_at(2046 + b));
      end
      frame_end();

      // R6 status read repeats
      sr_rdata = 8'h5A;
      frame_start(1'b0);
      byte8(8'h05, r);
      for (int b = 0; b < 2; b++) begin
         byte8(8'h00, r);
         chk(r == 8'h5A, "R6", "status byte", r, 8'h5A);
      end
      frame_end();

      // R7 status write takes only the first byte
      frame_start(1'b1);
      byte8(8'h01, r); byte8(8'h3C, r); byte8(8'h77, r);
      frame_end();
      chk(srq.size() == 1, "R7", "status write count", srq.size(), 1);
      if (srq.size() == 1) chk(srq[0] == 8'h3C, "R7", "status write data", srq[0], 8'h3C);

      // R8 hold inside an address byte and inside a data byte
      frame_start(1'b0);
      byte8(8'h03, r); byte8(8'h01, r);
      xfer(8'h23, 8, 3, r);
      byte8(8'h00, r);
      chk(r == mem_at(12'h123), "R8", "read after address hold", r, mem_at(12'h123));
      xfer(8'h00, 8, 4, r);
      chk(r == mem_at(12'h124), "R8", "read across data hold", r, mem_at(12'h124));
      byte8(8'h00, r);
      chk(r == mem_at(12'h125), "R8", "read after hold", r, mem_at(12'h125));
      frame_end();

      // R10 aborted frames leave no strobe
      ws = wq.size(); ns = n_set;
      frame_start(1'b0); byte8(8'h02, r); byte8(8'h00, r); xfer(8'h40, 4, -1, r); frame_end();
      frame_start(1'b1); xfer(8'h06, 5, -1, r); frame_end();
      chk(wq.size() == ws && n_set == ns, "R10", "strobes after abort", wq.size() + n_set, ws + ns);
      frame_start(1'b0); byte8(8'h06, r); frame_end();
      chk(n_set == ns + 1, "R10", "opcode after abort", n_set, ns + 1);

      // R11 unknown opcode ignored until deselect
      ws = wq.size(); ss = srq.size(); ns = n_set; nc = n_clr;
      frame_start(1'b0);
      byte8(8'hAB, r);
      foreach (r[k]) ; // no-op
      byte8(8'h02, r); chk(!so_oe, "R11", "so_oe after unknown", so_oe, 0);
      byte8(8'h06, r); byte8(8'h03, r); byte8(8'h55, r);
      chk(!so_oe, "R11", "so_oe later", so_oe, 0);
      frame_end();
      chk(wq.size() == ws && srq.size() == ss && n_set == ns && n_clr == nc,
          "R11", "strobes after unknown", wq.size() + srq.size() + n_set + n_clr,
          ws + ss + ns + nc);
      frame_start(1'b0); byte8(8'h04, r); frame_end();
      chk(n_clr == nc + 1, "R11", "decode resumes after deselect", n_clr, nc + 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule